// File: doc/BRIEF.md
# Carrier Interrupt Status and Aggregation

This block is the interrupt front end of a carrier board that hosts four plug-in I/O modules, named A to D. Each module drives two active-low interrupt request lines and one active-low error line. The carrier also produces an internal access time-out event, which arrives as a single-cycle pulse. The block merges these sources into one active-low interrupt toward the host. It exposes two 16-bit registers on a simple synchronous read/write port: a control/status word and a read-only pending word.

Every request and error line passes through a two-flop synchronizer and is inverted, so an internal 1 means active. Module pending bits track the live synchronized request levels. They are not sticky, and software cannot clear them. The time-out interrupt is held by a small state machine with three states. In TMO_OFF the time-out enable is 0. In TMO_ARMED the enable is 1 and nothing is pending. In TMO_PENDING the enable is 1 and a time-out has been captured. The transitions are named as follows. ARM goes from OFF to ARMED on a control write with bit 3 set. CAPTURE goes from ARMED to PENDING on a time-out pulse. DISARM goes from ARMED or PENDING to OFF on a control write with bit 3 clear. All other conditions hold the current state.

Software reads the pending word to find out which source asked for service. The enable bits only gate the host output. Status stays visible whatever the enable settings.

Top module: `carrier_irq_front`

## Requirements
- R1: After reset, the control/status word reads 0x0000, the pending word reads 0x0000 and `host_irq_n` is 1, whatever the request and error lines do during reset.
- R2: Pending word bits 0 to 7 show request lines `req_n[0..7]`, in the order A Int0, A Int1, B Int0, B Int1, C Int0, C Int1, D Int0, D Int1. A bit reads 1 two clock edges after its line is driven low.
- R3: A module pending bit clears two edges after its line returns high, and it reflects the line whether or not module interrupts are enabled.
- R4: Control/status bit 1 is read-only and reads 1 whenever any module pending bit is 1, even with the module enable at 0.
- R5: Control/status bit 0 is read-only and reads 1 while any synchronized error line is active, and 0 when all four are inactive.
- R6: Control/status bit 2 is a read/write module interrupt enable. `host_irq_n` is 0 when bit 2 is 1 and any module pending bit is 1.
- R7: Control/status bit 3 is a read/write time-out enable. A `tmo_pulse` sets pending word bit 10 only if bit 3 was already 1 before the pulse edge. A pulse in the same cycle as the write that sets bit 3 is not captured.
- R8: Writing bit 3 as 0 clears pending bit 10, and this write wins over a pulse in the same cycle. Writing bit 3 as 1 while a time-out is pending keeps it pending.
- R9: `host_irq_n` is 0 while bit 3 is 1 and pending bit 10 is 1. In every other case, with the module path inactive, it is 1.
- R10: Writes to the pending word (`reg_sel`=1) change nothing. Writes to control/status bits 0, 1 and 4 to 15 have no effect. Those bits, and pending bits 8, 9 and 11 to 15, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 8 | Module interrupt request lines, active low, in the R2 order |
| err_n | input | 4 | Module error lines, active low, one per module A to D |
| tmo_pulse | input | 1 | Single-cycle access time-out event |
| reg_sel | input | 1 | Register select: 0 is control/status, 1 is pending |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational on `reg_sel` |
| host_irq_n | output | 1 | Host interrupt, active low |

## Verification
The embedded assertions check, on every cycle, the rules that hold at each edge. The host output must be asserted whenever an enabled source is pending, and it must stay quiet when no source is enabled. A time-out capture may only follow an armed pulse. A disabling write must always leave the time-out path idle. Writes to the pending word must never move the enables. The bench's scenarios are needed for everything that depends on ordering and latency. That covers the bit order of the pending word, the two-edge synchronizer delay, pending bits that follow the level without the enable, and the two races between a pulse and a control write in the same cycle. A reference model written in the bench is compared against both registers and the host output on every clock.

// File: rtl/carrier_irq_pkg.sv
package carrier_irq_pkg;

    // control/status word field positions
    localparam int CSR_ERR_BIT    = 0;
    localparam int CSR_ANY_BIT    = 1;
    localparam int CSR_MOD_EN_BIT = 2;
    localparam int CSR_TMO_EN_BIT = 3;

    // pending word: time-out flag position in the upper byte
    localparam int PND_TMO_BIT    = 10;

    typedef enum logic [1:0] {
        TMO_OFF     = 2'd0,
        TMO_ARMED   = 2'd1,
        TMO_PENDING = 2'd2
    } tmo_state_t;

endpackage

// File: rtl/cirq_sync.sv
module cirq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_n,
    output logic [WIDTH-1:0] q_act
);

    logic [WIDTH-1:0] stg [STAGES];

    // first stage inverts so that a stored 1 means active
    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= ~d_n;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q_act = stg[STAGES-1];

endmodule

// File: rtl/cirq_tmo_fsm.sv
module cirq_tmo_fsm
    import carrier_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_en_val,
    input  logic tmo_pulse,
    output logic tmo_en,
    output logic tmo_pend
);

    tmo_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TMO_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TMO_OFF: begin
                if (wr_stb && wr_en_val) state_d = TMO_ARMED;      // ARM
            end
            TMO_ARMED: begin
                if (wr_stb && !wr_en_val) state_d = TMO_OFF;       // DISARM
                else if (tmo_pulse)       state_d = TMO_PENDING;   // CAPTURE
            end
            TMO_PENDING: begin
                if (wr_stb && !wr_en_val) state_d = TMO_OFF;       // DISARM
            end
            default: state_d = TMO_OFF;
        endcase
    end

    always_comb begin
        tmo_en   = 1'b0;
        tmo_pend = 1'b0;
        unique case (state_q)
            TMO_OFF:     begin tmo_en = 1'b0; tmo_pend = 1'b0; end
            TMO_ARMED:   begin tmo_en = 1'b1; tmo_pend = 1'b0; end
            TMO_PENDING: begin tmo_en = 1'b1; tmo_pend = 1'b1; end
            default:     begin tmo_en = 1'b0; tmo_pend = 1'b0; end
        endcase
    end

    // R7: a capture only follows a pulse seen while armed
    assert_capture_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_pend) |-> ($past(tmo_pulse) && $past(tmo_en)));

    // R8: a disabling write always leaves the path idle
    assert_disarm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_en_val) |=> (!tmo_pend && !tmo_en));

endmodule

// File: rtl/cirq_csr.sv
module cirq_csr
    import carrier_irq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REQ  = 8,
    parameter int NUM_ERR  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               csr_wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               sel_pend,
    input  logic [NUM_REQ-1:0] mod_pend,
    input  logic [NUM_ERR-1:0] err_act,
    input  logic               tmo_en,
    input  logic               tmo_pend,
    output logic               mod_en,
    output logic [DATA_W-1:0]  rdata
);

    logic [DATA_W-1:0] csr_word, pnd_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mod_en <= 1'b0;
        else if (csr_wr) mod_en <= wdata[CSR_MOD_EN_BIT];
    end

    always_comb begin
        csr_word                 = '0;
        csr_word[CSR_ERR_BIT]    = |err_act;
        csr_word[CSR_ANY_BIT]    = |mod_pend;
        csr_word[CSR_MOD_EN_BIT] = mod_en;
        csr_word[CSR_TMO_EN_BIT] = tmo_en;
    end

    always_comb begin
        pnd_word              = '0;
        pnd_word[NUM_REQ-1:0] = mod_pend;
        pnd_word[PND_TMO_BIT] = tmo_pend;
    end

    assign rdata = sel_pend ? pnd_word : csr_word;

    // R10: the enable register moves only on a control write
    assert_enable_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_wr |=> $stable(mod_en));

endmodule

// File: rtl/carrier_irq_front.sv
module carrier_irq_front
    import carrier_irq_pkg::*;
#(
    parameter int NUM_MODS     = 4,
    parameter int REQS_PER_MOD = 2,
    parameter int DATA_W       = 16,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_MODS*REQS_PER_MOD-1:0]   req_n,
    input  logic [NUM_MODS-1:0]                err_n,
    input  logic                               tmo_pulse,
    input  logic                               reg_sel,
    input  logic                               reg_wr,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic                               host_irq_n
);

    localparam int NUM_REQ = NUM_MODS * REQS_PER_MOD;

    logic [NUM_REQ-1:0]  mod_pend;
    logic [NUM_MODS-1:0] err_act;
    logic                csr_wr, mod_en, tmo_en, tmo_pend;

    assign csr_wr = reg_wr && !reg_sel;

    cirq_sync #(.WIDTH(NUM_REQ), .STAGES(SYNC_STAGES)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d_n(req_n), .q_act(mod_pend)
    );

    cirq_sync #(.WIDTH(NUM_MODS), .STAGES(SYNC_STAGES)) u_err_sync (
        .clk(clk), .rst_n(rst_n), .d_n(err_n), .q_act(err_act)
    );

    cirq_tmo_fsm u_tmo (
        .clk(clk), .rst_n(rst_n),
        .wr_stb(csr_wr), .wr_en_val(reg_wdata[CSR_TMO_EN_BIT]),
        .tmo_pulse(tmo_pulse), .tmo_en(tmo_en), .tmo_pend(tmo_pend)
    );

    cirq_csr #(.DATA_W(DATA_W), .NUM_REQ(NUM_REQ), .NUM_ERR(NUM_MODS)) u_csr (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .wdata(reg_wdata),
        .sel_pend(reg_sel), .mod_pend(mod_pend), .err_act(err_act),
        .tmo_en(tmo_en), .tmo_pend(tmo_pend), .mod_en(mod_en), .rdata(reg_rdata)
    );

    assign host_irq_n = !((mod_en && (|mod_pend)) || (tmo_en && tmo_pend));

    // R6: an enabled module request reaches the host
    assert_mod_irq_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && (|mod_pend)) |-> !host_irq_n);

    // R9: an enabled captured time-out reaches the host
    assert_tmo_irq_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_en && tmo_pend) |-> !host_irq_n);

    // R6, R9: nothing enabled means a quiet host line
    assert_quiet_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_en && !tmo_en) |-> host_irq_n);

    // R10: writes aimed at the pending word leave the time-out enable alone
    assert_pend_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> $stable(tmo_en));

endmodule

// File: tb/carrier_irq_front_tb.sv
module carrier_irq_front_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req_n = 8'hFF;
    logic [3:0]  err_n = 4'hF;
    logic        tmo_pulse = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'h0;
    logic [15:0] reg_rdata;
    logic        host_irq_n;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    carrier_irq_front u_dut (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .err_n(err_n),
        .tmo_pulse(tmo_pulse), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq_n(host_irq_n)
    );

    // behavioural reference model
    logic [7:0] m_req1, m_req2;
    logic [3:0] m_err1, m_err2;
    logic       m_mod_en, m_tmo_en, m_tmo_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_req1 <= 0; m_req2 <= 0; m_err1 <= 0; m_err2 <= 0;
            m_mod_en <= 0; m_tmo_en <= 0; m_tmo_pend <= 0;
        end else begin
            m_req1 <= ~req_n; m_req2 <= m_req1;
            m_err1 <= ~err_n; m_err2 <= m_err1;
            if (reg_wr && !reg_sel) begin
                m_mod_en <= reg_wdata[2];
                m_tmo_en <= reg_wdata[3];
            end
            if (reg_wr && !reg_sel && !reg_wdata[3]) m_tmo_pend <= 1'b0;
            else if (m_tmo_en && tmo_pulse)          m_tmo_pend <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // compare against the model on every clock
    always @(negedge clk) begin
        logic [15:0] e_csr, e_pnd;
        logic        e_irq;
        e_csr = {12'h0, m_tmo_en, m_mod_en, |m_req2, |m_err2};
        e_pnd = {5'h0, m_tmo_pend, 2'b00, m_req2};
        e_irq = !((m_mod_en && |m_req2) || (m_tmo_en && m_tmo_pend));
        chk("R6,R9 host_irq_n", {15'h0, host_irq_n}, {15'h0, e_irq});
        if (reg_sel) begin
            chk("R2 pending low byte", {8'h0, reg_rdata[7:0]}, {8'h0, e_pnd[7:0]});
            chk("R7 pending time-out bit", {15'h0, reg_rdata[10]}, {15'h0, e_pnd[10]});
            chk("R10 pending unused bits", reg_rdata & 16'hFB00, 16'h0);
        end else begin
            chk("R5 error bit", {15'h0, reg_rdata[0]}, {15'h0, e_csr[0]});
            chk("R4 any-pending bit", {15'h0, reg_rdata[1]}, {15'h0, e_csr[1]});
            chk("R6 enable bits", {14'h0, reg_rdata[3:2]}, {14'h0, e_csr[3:2]});
            chk("R10 csr unused bits", reg_rdata & 16'hFFF0, 16'h0);
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            reg_wr = 0; tmo_pulse = 0;
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d, input logic pulse);
        @(posedge clk); #1;
        reg_wr = 1; reg_sel = sel; reg_wdata = d; tmo_pulse = pulse;
        @(posedge clk); #1;
        reg_wr = 0; tmo_pulse = 0; reg_sel = 0;
    endtask

    task automatic fire;
        @(posedge clk); #1; tmo_pulse = 1;
        @(posedge clk); #1; tmo_pulse = 0;
    endtask

    task automatic expect_rd(input logic sel, input logic [15:0] exp, input string tag);
        @(posedge clk); #1; reg_sel = sel; reg_wr = 0; tmo_pulse = 0;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
    endtask

    task automatic expect_irq(input logic exp, input string tag);
        @(negedge clk);
        chk(tag, {15'h0, host_irq_n}, {15'h0, exp});
    endtask

    initial begin
        #40000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: lines active during reset must not show
        req_n = 8'h00; err_n = 4'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 csr at reset", reg_rdata, 16'h0000);
        chk("R1 host at reset", {15'h0, host_irq_n}, 16'h0001);
        req_n = 8'hFF; err_n = 4'hF;
        idle(3);
        rst_n = 1;
        expect_rd(1'b1, 16'h0000, "R1 pending after reset");
        expect_rd(1'b0, 16'h0000, "R1 csr after reset");

        // R2, R3: each line alone, bit order and release
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); #1; req_n = ~(8'h01 << i);
            expect_rd(1'b1, 16'h0000, "R2 one edge latency");
            expect_rd(1'b1, 16'h0001 << i, "R2 bit order");
            @(posedge clk); #1; req_n = 8'hFF;
            idle(2);
            expect_rd(1'b1, 16'h0000, "R3 release clears");
        end

        // R5: each error line
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1; err_n = ~(4'h1 << i);
            idle(2);
            expect_rd(1'b0, 16'h0001, "R5 error visible");
            @(posedge clk); #1; err_n = 4'hF;
            idle(2);
            expect_rd(1'b0, 16'h0000, "R5 error gone");
        end

        // R4, R3: pending without enable, host quiet
        @(posedge clk); #1; req_n = 8'hFB;        // B Int0
        idle(3);
        expect_rd(1'b0, 16'h0002, "R4 any-pending with enable off");
        expect_irq(1'b1, "R6 host quiet with enable off");
        // R6: enable module path
        wr(1'b0, 16'h0004, 1'b0);
        expect_irq(1'b0, "R6 host asserted");
        expect_rd(1'b0, 16'h0006, "R6 enable readback");
        @(posedge clk); #1; req_n = 8'hFF;
        idle(3);
        expect_irq(1'b1, "R6 host released with line");
        wr(1'b0, 16'h0000, 1'b0);

        // R7: pulse with time-out disabled is dropped
        fire();
        expect_rd(1'b1, 16'h0000, "R7 pulse ignored when disabled");
        wr(1'b0, 16'h0008, 1'b0);
        expect_rd(1'b1, 16'h0000, "R7 armed, nothing pending");
        fire();
        expect_rd(1'b1, 16'h0400, "R7 capture at bit 10");
        expect_irq(1'b0, "R9 host asserted by time-out");
        wr(1'b0, 16'h0008, 1'b0);
        expect_rd(1'b1, 16'h0400, "R8 rewrite of 1 keeps pending");
        wr(1'b0, 16'h0000, 1'b0);
        expect_rd(1'b1, 16'h0000, "R8 write 0 clears");
        expect_irq(1'b1, "R9 host released");
        // R8: disabling write beats pulse
        wr(1'b0, 16'h0008, 1'b0);
        wr(1'b0, 16'h0000, 1'b1);
        expect_rd(1'b1, 16'h0000, "R8 write 0 wins over pulse");
        // R7: pulse with the arming write is not captured
        wr(1'b0, 16'h0008, 1'b1);
        expect_rd(1'b1, 16'h0000, "R7 pulse with arming write dropped");
        expect_rd(1'b0, 16'h0008, "R7 enable set");

        // R10: writes to pending word and to read-only bits
        wr(1'b1, 16'hFFFF, 1'b0);
        expect_rd(1'b0, 16'h0008, "R10 pending write ignored");
        wr(1'b0, 16'hFFF3, 1'b0);
        expect_rd(1'b0, 16'h0000, "R10 read-only bits unwritten");
        wr(1'b0, 16'h0000, 1'b0);

        // mixed traffic against the model
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            req_n     = 8'($urandom);
            err_n     = 4'($urandom | 32'h6);
            tmo_pulse = ($urandom % 6) == 0;
            reg_sel   = 1'($urandom);
            reg_wr    = ($urandom % 5) == 0;
            reg_wdata = 16'($urandom);
        end
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule